// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Global Entries

This block is a small, fully associative cache of virtual-to-physical page translations. Each cached entry carries the address-space context under which it was loaded and a global mark. A lookup port takes a virtual page number and the current context. In the same cycle it returns hit or miss, the physical frame number, the user and write permission bits, and whether the hit came from a global entry. The surrounding core supplies translations through a fill port, one leaf page-table entry at a time. Maintenance pulses remove entries: a page-table-base switch, a single-page invalidate, an invalidate-by-context and a full flush.

Global marking lets kernel mappings, which are identical in every address space, survive address-space switches and hit under any context. The mark is set only when the global-enable bit of the mode input is set. The fill port carries both 4 KiB mappings and 2 MiB mappings from a directory-level entry with the page-size bit set.

The fill port is a valid/ready stream. `fill_ready` is low during reset and goes high on the first clock after reset is released. After that it stays high, so the port never applies back-pressure. A fill transfers on every rising edge where `fill_valid` and `fill_ready` are both high.

Top module: `ctx_tlb`

## Requirements
- R1: A transferred fill is cached only when `fill_pte` bit 0 (present) is 1 and the entry maps a page. Mapping a page means `fill_dir`=0 (4 KiB), or `fill_dir`=1 with `fill_pte` bit 7 (page size) set to 1 (2 MiB). Any other fill leaves the cache unchanged. The frame number is `fill_pte[31:12]`. The entry is tagged with `cur_ctx`.
- R2: An entry is global only when `mode_reg` bit 7 was 1 and `fill_pte` bit 8 was 1 at fill time. Otherwise it is non-global, whatever bit 8 holds. `lk_global` reports the flag of the hitting entry.
- R3: A global entry hits for a matching page under any `cur_ctx`. A non-global entry hits only when its stored context equals `cur_ctx`.
- R4: For a 2 MiB entry, the low 9 bits of the virtual page number are left out of the compare. On a hit they replace the low 9 bits of the returned frame number.
- R5: A `ptb_switch` pulse removes every non-global entry and keeps every global one.
- R6: An `inv_page` pulse removes every entry that maps `inv_vpn`, under any context, including global entries. A 2 MiB entry is removed for any address in its 2 MiB region.
- R7: Reset and an `inv_all` pulse each leave the cache empty, global entries included.
- R8: An `inv_ctx` pulse removes only the non-global entries whose context equals `inv_ctx_id`.
- R9: Lookup is combinational. On a miss, `lk_pfn`, `lk_user`, `lk_write` and `lk_global` are all 0.
- R10: Fills and invalidations take effect at the next rising edge. When both occur in one cycle, the invalidation is applied first and the fill is then written.
- R11: A fill whose page matches an existing entry that is global or carries `cur_ctx` overwrites that entry instead of allocating a new one.
- R12: The cache holds 16 entries. New allocations use round-robin order, so after 17 distinct allocations the first one loaded is gone and the others remain.
- R13: `fill_pte` bit 2 (user) and bit 1 (write) are stored per entry and returned on a hit as `lk_user` and `lk_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_reg | input | 8 | Mode control; bit 7 enables global entries |
| cur_ctx | input | 12 | Current context, used for lookup and as the fill tag |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number on a hit |
| lk_user | output | 1 | User-access permission of the hit entry |
| lk_write | output | 1 | Write permission of the hit entry |
| lk_global | output | 1 | Hit entry is global |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill accepted; high from the first cycle after reset |
| fill_dir | input | 1 | Entry comes from directory level (large page if bit 7 set) |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pte | input | 32 | Leaf page-table entry |
| ptb_switch | input | 1 | Page-table base switch pulse |
| inv_page | input | 1 | Single-page invalidate pulse |
| inv_vpn | input | 20 | Page number for `inv_page` |
| inv_all | input | 1 | Full flush pulse |
| inv_ctx | input | 1 | Invalidate-by-context pulse |
| inv_ctx_id | input | 12 | Context for `inv_ctx` |

## Verification
The bench targets these cases:
- A global-tagged fill made while the enable bit is clear. A design that honoured bit 8 anyway would hit under a foreign context.
- A single-page invalidate aimed at a global entry and at an address inside a 2 MiB region. A design that compared the full page number, or skipped global entries, would keep serving a stale translation.
- A fill that lands in the same cycle as a full flush. A design that applied the flush after the fill would lose the new entry.
- A same-page refill. Getting it wrong shows up either as the old frame number or as an extra allocation.
- A run of seventeen allocations. A design with the wrong round-robin order would evict the wrong victim.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  // Leaf entry bit positions
  localparam int PTE_PRESENT = 0;
  localparam int PTE_WRITE   = 1;
  localparam int PTE_USER    = 2;
  localparam int PTE_PSIZE   = 7;
  localparam int PTE_GLOBAL  = 8;
  localparam int PTE_FRAME   = 12;
  // Mode register: global-entry enable
  localparam int MODE_GEN    = 7;

  typedef struct packed {
    logic glob;
    logic big;
    logic user;
    logic wr;
  } tlb_attr_t;
endpackage

// File: rtl/ctx_tlb_slot.sv
module ctx_tlb_slot #(
  parameter int VPN_W   = 20,
  parameter int CTX_W   = 12,
  parameter int LP_BITS = 9
) (
  input  logic                    ent_v,
  input  logic [VPN_W-1:0]        ent_vpn,
  input  logic [CTX_W-1:0]        ent_ctx,
  input  ctx_tlb_pkg::tlb_attr_t  ent_attr,
  input  logic [CTX_W-1:0]        cur_ctx,
  input  logic [VPN_W-1:0]        lk_vpn,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [VPN_W-1:0]        inv_vpn,
  output logic                    lk_m,
  output logic                    fill_m,
  output logic                    inv_m
);
  localparam int HI_W = VPN_W - LP_BITS;

  function automatic logic page_eq(input logic [VPN_W-1:0] a);
    if (ent_attr.big) return a[VPN_W-1 -: HI_W] == ent_vpn[VPN_W-1 -: HI_W];
    return a == ent_vpn;
  endfunction

  logic ctx_ok;
  assign ctx_ok = ent_attr.glob || (ent_ctx == cur_ctx);
  assign lk_m   = ent_v && ctx_ok && page_eq(lk_vpn);
  assign fill_m = ctx_ok && page_eq(fill_vpn);
  assign inv_m  = page_eq(inv_vpn);
endmodule

// File: rtl/ctx_tlb_rr.sv
module ctx_tlb_rr #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int N       = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int CTX_W   = 12,
  parameter int PTE_W   = 32,
  parameter int LP_BITS = 9,
  parameter int MODE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_reg,
  input  logic [CTX_W-1:0]  cur_ctx,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_user,
  output logic              lk_write,
  output logic              lk_global,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_dir,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic              ptb_switch,
  input  logic              inv_page,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              inv_all,
  input  logic              inv_ctx,
  input  logic [CTX_W-1:0]  inv_ctx_id
);
  import ctx_tlb_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int HI_W  = PFN_W - LP_BITS;

  logic [N-1:0]     ent_v;
  logic [VPN_W-1:0] ent_vpn  [N];
  logic [CTX_W-1:0] ent_ctx  [N];
  logic [PFN_W-1:0] ent_pfn  [N];
  tlb_attr_t        ent_attr [N];

  logic [N-1:0] lk_m, fill_m, inv_m, keep_v;

  for (genvar g = 0; g < N; g++) begin : g_slot
    ctx_tlb_slot #(.VPN_W(VPN_W), .CTX_W(CTX_W), .LP_BITS(LP_BITS)) u_slot (
      .ent_v(ent_v[g]), .ent_vpn(ent_vpn[g]), .ent_ctx(ent_ctx[g]),
      .ent_attr(ent_attr[g]), .cur_ctx(cur_ctx), .lk_vpn(lk_vpn),
      .fill_vpn(fill_vpn), .inv_vpn(inv_vpn),
      .lk_m(lk_m[g]), .fill_m(fill_m[g]), .inv_m(inv_m[g])
    );
    // Invalidations resolve before any fill of the same cycle
    assign keep_v[g] = ent_v[g] && !inv_all
                     && !(ptb_switch && !ent_attr[g].glob)
                     && !(inv_ctx && !ent_attr[g].glob && ent_ctx[g] == inv_ctx_id)
                     && !(inv_page && inv_m[g]);
  end

  // Fill qualification
  logic fill_ok;
  assign fill_ok = fill_valid && fill_ready && fill_pte[PTE_PRESENT]
                && (!fill_dir || fill_pte[PTE_PSIZE]);

  logic             dup_any;
  logic [IDX_W-1:0] dup_idx, rr_ptr, wr_idx;
  always_comb begin
    dup_any = 1'b0;
    dup_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (keep_v[i] && fill_m[i]) begin
        dup_any = 1'b1;
        dup_idx = IDX_W'(i);
      end
    end
  end
  assign wr_idx = dup_any ? dup_idx : rr_ptr;

  ctx_tlb_rr #(.N(N)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_ok && !dup_any), .ptr(rr_ptr)
  );

  tlb_attr_t new_attr;
  always_comb begin
    new_attr.glob = mode_reg[MODE_GEN] && fill_pte[PTE_GLOBAL];
    new_attr.big  = fill_dir;
    new_attr.user = fill_pte[PTE_USER];
    new_attr.wr   = fill_pte[PTE_WRITE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v      <= '0;
      fill_ready <= 1'b0;
    end else begin
      fill_ready <= 1'b1;
      ent_v      <= keep_v;
      if (fill_ok) ent_v[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      ent_vpn[wr_idx]  <= fill_vpn;
      ent_ctx[wr_idx]  <= cur_ctx;
      ent_pfn[wr_idx]  <= fill_pte[PTE_FRAME +: PFN_W];
      ent_attr[wr_idx] <= new_attr;
    end
  end

  // Lookup: lowest matching index wins
  always_comb begin
    lk_hit    = 1'b0;
    lk_pfn    = '0;
    lk_user   = 1'b0;
    lk_write  = 1'b0;
    lk_global = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_m[i]) begin
        lk_hit    = 1'b1;
        lk_pfn    = ent_attr[i].big ? {ent_pfn[i][PFN_W-1 -: HI_W], lk_vpn[LP_BITS-1:0]}
                                    : ent_pfn[i];
        lk_user   = ent_attr[i].user;
        lk_write  = ent_attr[i].wr;
        lk_global = ent_attr[i].glob;
      end
    end
  end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CTX_W = 12,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTX_W-1:0] cur_ctx,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             lk_user,
  input logic             lk_write,
  input logic             lk_global,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             fill_dir,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PTE_W-1:0] fill_pte,
  input logic             ptb_switch,
  input logic             inv_page,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             inv_all,
  input logic             inv_ctx,
  input logic [CTX_W-1:0] inv_ctx_id
);
  import ctx_tlb_pkg::*;
  logic fill_take;
  assign fill_take = fill_valid && fill_ready && fill_pte[PTE_PRESENT]
                  && (!fill_dir || fill_pte[PTE_PSIZE]);

  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0 && !lk_user && !lk_write && !lk_global));

  a_r1_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> (lk_vpn != $past(fill_vpn) || cur_ctx != $past(cur_ctx) || lk_hit));

  a_r5_switch_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb_switch && !fill_valid) |=> (!lk_hit || lk_global));

  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_valid) |=> !lk_hit);

  a_r8_ctx_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_ctx && !fill_valid) |=> !(lk_hit && !lk_global && cur_ctx == $past(inv_ctx_id)));

  a_r6_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_page && !fill_valid) |=> !(lk_hit && lk_vpn == $past(inv_vpn)));
endmodule

bind ctx_tlb ctx_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;
  localparam int CLK_P = 10;
  localparam int NE = 16;

  logic clk = 0, rst_n = 0;
  logic [7:0] mode_reg = 0;
  logic [11:0] cur_ctx = 0, inv_ctx_id = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0;
  logic [31:0] fill_pte = 0;
  logic fill_valid = 0, fill_dir = 0, ptb_switch = 0, inv_page = 0, inv_all = 0, inv_ctx = 0;
  logic lk_hit, lk_user, lk_write, lk_global, fill_ready;
  logic [19:0] lk_pfn;

  ctx_tlb u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0;
  string tag = "R7";

  // Behavioural reference
  bit m_v[NE]; bit m_g[NE]; bit m_big[NE]; bit m_u[NE]; bit m_w[NE];
  logic [19:0] m_vpn[NE]; logic [19:0] m_pfn[NE]; logic [11:0] m_ctx[NE];
  int m_ptr = 0;
  bit mh, mu, mw, mg; logic [19:0] mpfn;

  function automatic bit covers(int i, logic [19:0] v);
    return m_big[i] ? (v[19:9] == m_vpn[i][19:9]) : (v == m_vpn[i]);
  endfunction

  task automatic model_look(logic [19:0] v, logic [11:0] c);
    mh = 0; mu = 0; mw = 0; mg = 0; mpfn = 0;
    for (int i = NE - 1; i >= 0; i--)
      if (m_v[i] && covers(i, v) && (m_g[i] || m_ctx[i] == c)) begin
        mh = 1; mu = m_u[i]; mw = m_w[i]; mg = m_g[i];
        mpfn = m_big[i] ? {m_pfn[i][19:9], v[8:0]} : m_pfn[i];
      end
  endtask

  task automatic model_update();
    int slot;
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      m_ptr = 0;
      return;
    end
    for (int i = 0; i < NE; i++) begin
      if (inv_all) m_v[i] = 0;
      if (ptb_switch && !m_g[i]) m_v[i] = 0;
      if (inv_ctx && !m_g[i] && m_ctx[i] == inv_ctx_id) m_v[i] = 0;
      if (inv_page && covers(i, inv_vpn)) m_v[i] = 0;
    end
    if (fill_valid && fill_ready && fill_pte[0] && (!fill_dir || fill_pte[7])) begin
      slot = -1;
      for (int i = NE - 1; i >= 0; i--)
        if (m_v[i] && covers(i, fill_vpn) && (m_g[i] || m_ctx[i] == cur_ctx)) slot = i;
      if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % NE; end
      m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_ctx[slot] = cur_ctx;
      m_pfn[slot] = fill_pte[31:12]; m_big[slot] = fill_dir;
      m_g[slot] = mode_reg[7] & fill_pte[8]; m_u[slot] = fill_pte[2]; m_w[slot] = fill_pte[1];
    end
  endtask

  task automatic check(string t, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  task automatic compare_model();
    model_look(lk_vpn, cur_ctx);
    check(tag, "hit", 32'(lk_hit), 32'(mh));
    check(tag, "pfn", 32'(lk_pfn), 32'(mpfn));
    check(tag, "perm", {30'd0, lk_user, lk_write}, {30'd0, mu, mw});
    check(tag, "global", 32'(lk_global), 32'(mg));
  endtask

  task automatic tick();
    #1;
    if (rst_n) compare_model();
    @(posedge clk);
    model_update();
    @(negedge clk);
    fill_valid = 0; ptb_switch = 0; inv_page = 0; inv_all = 0; inv_ctx = 0;
  endtask

  function automatic logic [31:0] mk_pte(logic [19:0] pfn, bit g, bit ps, bit u, bit w, bit p);
    return {pfn, 3'b000, g, ps, 4'b0000, u, w, p};
  endfunction

  task automatic fill(logic [19:0] v, logic [31:0] pte, bit dir);
    fill_valid = 1; fill_vpn = v; fill_pte = pte; fill_dir = dir;
    tick();
  endtask

  // Explicit expectation at the ports, then one idle cycle
  task automatic probe(string t, logic [19:0] v, logic [11:0] c, bit eh, logic [19:0] ep);
    lk_vpn = v; cur_ctx = c;
    #1;
    check(t, "probe hit", 32'(lk_hit), 32'(eh));
    check(t, "probe pfn", 32'(lk_pfn), 32'(ep));
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    model_update();
    rst_n = 1;
    // R7: empty after reset
    tag = "R7"; probe("R7", 20'h00100, 12'd5, 0, 0);
    // R1, R13, R3
    tag = "R1"; cur_ctx = 5;
    fill(20'h00100, mk_pte(20'hABCDE, 0, 0, 0, 1, 1), 0);
    probe("R1", 20'h00100, 12'd5, 1, 20'hABCDE);
    check("R13", "write", 32'(lk_write), 32'd1);
    probe("R3", 20'h00100, 12'd6, 0, 0);
    cur_ctx = 5; fill(20'h00200, mk_pte(20'h11111, 0, 0, 0, 0, 0), 0);
    probe("R1", 20'h00200, 12'd5, 0, 0);
    cur_ctx = 5; fill(20'h00300, mk_pte(20'h22222, 0, 0, 0, 0, 1), 1);
    probe("R1", 20'h00300, 12'd5, 0, 0);
    tag = "R13"; cur_ctx = 5; fill(20'h00400, mk_pte(20'h33333, 0, 0, 1, 0, 1), 0);
    lk_vpn = 20'h00400; #1;
    check("R13", "user", 32'(lk_user), 32'd1);
    check("R13", "write", 32'(lk_write), 32'd0);
    tick();
    // R2: global needs mode bit 7
    tag = "R2"; mode_reg = 8'h00; cur_ctx = 1;
    fill(20'h00500, mk_pte(20'h44444, 1, 0, 0, 0, 1), 0);
    probe("R2", 20'h00500, 12'd2, 0, 0);
    probe("R2", 20'h00500, 12'd1, 1, 20'h44444);
    mode_reg = 8'h80; cur_ctx = 1;
    fill(20'h00600, mk_pte(20'h55555, 1, 0, 0, 0, 1), 0);
    lk_vpn = 20'h00600; cur_ctx = 2; #1;
    check("R2", "global flag", 32'(lk_global), 32'd1);
    tick();
    probe("R3", 20'h00600, 12'd9, 1, 20'h55555);
    // R4: 2 MiB page
    tag = "R4"; cur_ctx = 1;
    fill(20'h40200, mk_pte(20'h12345, 0, 1, 0, 1, 1), 1);
    probe("R4", 20'h403FF, 12'd1, 1, 20'h123FF);
    probe("R4", 20'h40400, 12'd1, 0, 0);
    // R5: base switch
    tag = "R5"; ptb_switch = 1; tick();
    probe("R5", 20'h00600, 12'd3, 1, 20'h55555);
    probe("R5", 20'h00500, 12'd1, 0, 0);
    probe("R5", 20'h00100, 12'd5, 0, 0);
    // R8: invalidate by context
    tag = "R8"; mode_reg = 8'h80;
    cur_ctx = 7; fill(20'h00700, mk_pte(20'h00007, 0, 0, 0, 0, 1), 0);
    cur_ctx = 8; fill(20'h00800, mk_pte(20'h00008, 0, 0, 0, 0, 1), 0);
    cur_ctx = 7; fill(20'h00900, mk_pte(20'h00009, 1, 0, 0, 0, 1), 0);
    inv_ctx = 1; inv_ctx_id = 7; tick();
    probe("R8", 20'h00700, 12'd7, 0, 0);
    probe("R8", 20'h00800, 12'd8, 1, 20'h00008);
    probe("R8", 20'h00900, 12'd7, 1, 20'h00009);
    // R6: single-page invalidate
    tag = "R6"; inv_page = 1; inv_vpn = 20'h00600; tick();
    probe("R6", 20'h00600, 12'd3, 0, 0);
    cur_ctx = 3; fill(20'h40000, mk_pte(20'h22000, 1, 1, 0, 0, 1), 1);
    probe("R4", 20'h40123, 12'd4, 1, 20'h22123);
    inv_page = 1; inv_vpn = 20'h401FF; tick();
    probe("R6", 20'h40000, 12'd3, 0, 0);
    cur_ctx = 3; inv_page = 1; inv_vpn = 20'h00800; tick();
    probe("R6", 20'h00800, 12'd8, 0, 0);
    // R10: flush and fill in the same cycle
    tag = "R10"; cur_ctx = 2; inv_all = 1;
    fill(20'h00A00, mk_pte(20'h0AAAA, 0, 0, 0, 0, 1), 0);
    probe("R10", 20'h00A00, 12'd2, 1, 20'h0AAAA);
    probe("R7", 20'h00900, 12'd7, 0, 0);
    // R11: refill overwrites
    tag = "R11"; cur_ctx = 2;
    fill(20'h00A00, mk_pte(20'h11111, 0, 0, 0, 0, 1), 0);
    probe("R11", 20'h00A00, 12'd2, 1, 20'h11111);
    // R7: full flush drops globals too
    tag = "R7"; cur_ctx = 2; fill(20'h00B00, mk_pte(20'h0BBBB, 1, 0, 0, 0, 1), 0);
    inv_all = 1; tick();
    probe("R7", 20'h00B00, 12'd2, 0, 0);
    // R12: round-robin eviction
    tag = "R12"; cur_ctx = 1;
    for (int k = 0; k < 17; k++) fill(20'h01000 + 20'(k), mk_pte(20'h70000 + 20'(k), 0, 0, 0, 0, 1), 0);
    probe("R12", 20'h01000, 12'd1, 0, 0);
    probe("R12", 20'h01001, 12'd1, 1, 20'h70001);
    probe("R12", 20'h01010, 12'd1, 1, 20'h70010);
    tag = "R9"; probe("R9", 20'hFFFFF, 12'd1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule